// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is a clocked model of the command front end of a byte-wide parallel NOR flash. Each clock cycle may carry one decoded bus write (a 16-bit address and a data byte) or one bus read. Writes are matched against fixed multi-write unlock sequences. A complete sequence launches one of three internal operations on a small on-chip byte array: a single-byte program, the erase of one uniform 4 KByte sector, or the erase of the whole array.

While an internal operation runs, the block is busy. It ignores every write, and reads return a polling status byte instead of stored data. The program duration is a parameter counted in clock cycles. An erase lasts one cycle per byte of its region, plus a parameterised tail. When the operation ends, reads return array contents again.

Programming can only clear bits. To restore bits to 1, the containing sector or the whole array must be erased first.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset, `busy` is 0 and `rdata` is 8'h00.
- R2: The four writes AAh@5555h, 55h@2AAAh, A0h@5555h, then (target address, data) start a program. `busy` rises in the cycle after the fourth write and stays high for exactly PROG_CYC cycles.
- R3: A program stores old AND data at the target byte (array index = address bits [ARRAY_AW-1:0]), so it never turns a 0 bit into a 1.
- R4: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address erase the sector selected by address bits [ARRAY_AW-1:SECTOR_AW]. Every byte of that sector becomes FFh. Bytes of other sectors keep their values.
- R5: The same five-write prefix followed by 10h@5555h sets every byte of the array to FFh.
- R6: An erase keeps `busy` high for the region size in bytes plus ERASE_TAIL cycles: 4096+ERASE_TAIL for a sector, 2^ARRAY_AW+ERASE_TAIL for the whole array.
- R7: A write that does not match the next expected step returns the decoder to idle. It starts no operation, and writes that would have completed the broken sequence change nothing. This includes a final 10h at an address other than 5555h, and a final byte other than 30h or 10h.
- R8: Writes received while `busy` is high are ignored, including a complete program sequence.
- R9: A read while busy returns the status byte. Bit 7 is the complement of bit 7 of the programmed data during a program, and 0 during an erase. Bit 6 inverts on each successive busy read. Bits 5:0 are 0.
- R10: `rdata` updates one cycle after a cycle with `rd_en` high and holds its value in every cycle without `rd_en`. When the block is idle, the read returns the array byte at the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe for this cycle |
| rd_en | input | 1 | Bus read strobe for this cycle |
| addr | input | 16 | Bus address for the read or write |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | An internal program or erase is running |

## Verification
The directed cases cover three kinds of sequence, each aimed at a different fault. Exact sequences check the launch timing and the busy duration of each operation kind. Sequences broken at different steps, or ended with a wrong final command or address, show whether the decoder leaks into a launch. A full program sequence issued during busy shows whether writes are gated. Repeated programs of one byte with opposing data distinguish AND-only programming from plain overwrite. A sector erase next to a programmed neighbouring sector separates the sector-bounded sweep from a whole-array one. The random phase then mixes programs at random addresses with random data, broken sequences and sector erases, and compares array reads against a bench shadow model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BUS_AW = 16;

    localparam logic [BUS_AW-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [BUS_AW-1:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [7:0] KEY_BYTE_A   = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B   = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_WHOLE    = 8'h10;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_SECT  = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_ER1,
        SQ_ER2,
        SQ_ER3
    } seq_e;

    typedef struct packed {
        op_e               kind;
        logic [BUS_AW-1:0] addr;
        logic [7:0]        data;
    } launch_t;

    function automatic logic bus_hit(input logic [BUS_AW-1:0] a, input logic [7:0] d,
                                     input logic [BUS_AW-1:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic logic [7:0] poll_status(input op_e kind, input logic [7:0] data,
                                               input logic tog);
        logic inv7;
        inv7 = (kind == OP_PROG) ? ~data[7] : 1'b0;
        return {inv7, tog, 6'b000000};
    endfunction

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    output launch_t           launch
);

    seq_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        launch  = '{kind: OP_NONE, addr: addr, data: wdata};
        if (wr_en && !busy) begin
            state_d = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: if (bus_hit(addr, wdata, KEY_ADDR_A, KEY_BYTE_A)) state_d = SQ_KEY1;
                SQ_KEY1: if (bus_hit(addr, wdata, KEY_ADDR_B, KEY_BYTE_B)) state_d = SQ_KEY2;
                SQ_KEY2: begin
                    if (bus_hit(addr, wdata, KEY_ADDR_A, CMD_PROGRAM))    state_d = SQ_PROG;
                    else if (bus_hit(addr, wdata, KEY_ADDR_A, CMD_ERASE)) state_d = SQ_ER1;
                end
                SQ_PROG: launch.kind = OP_PROG;
                SQ_ER1:  if (bus_hit(addr, wdata, KEY_ADDR_A, KEY_BYTE_A)) state_d = SQ_ER2;
                SQ_ER2:  if (bus_hit(addr, wdata, KEY_ADDR_B, KEY_BYTE_B)) state_d = SQ_ER3;
                SQ_ER3: begin
                    if (wdata == CMD_SECTOR)                              launch.kind = OP_SECT;
                    else if (bus_hit(addr, wdata, KEY_ADDR_A, CMD_WHOLE)) launch.kind = OP_CHIP;
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    // A write arriving while busy must not move the sequence (R8)
    p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state_q == $past(state_q)));

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int ARRAY_AW   = 13,
    parameter int SECTOR_AW  = 12,
    parameter int PROG_CYC   = 50,
    parameter int ERASE_TAIL = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  launch_t             launch,
    output logic                busy,
    output op_e                 op_kind,
    output logic [7:0]          op_data,
    output logic [ARRAY_AW-1:0] peek_addr,
    input  logic [7:0]          peek_q,
    output logic                mem_we,
    output logic                mem_clear_only,
    output logic [ARRAY_AW-1:0] mem_addr,
    output logic [7:0]          mem_wdata
);

    localparam int ARRAY_BYTES  = 1 << ARRAY_AW;
    localparam int SECTOR_BYTES = 1 << SECTOR_AW;
    localparam int MAX_CYC      = ARRAY_BYTES + ERASE_TAIL + PROG_CYC;
    localparam int CW           = $clog2(MAX_CYC + 1);
    localparam int SEL_W        = ARRAY_AW - SECTOR_AW;

    op_e                 kind_q;
    logic [CW-1:0]       cnt_q, last_q, span_q;
    logic [ARRAY_AW-1:0] base_q, tgt_q;
    logic [7:0]          data_q;
    logic                start;

    assign busy      = (kind_q != OP_NONE);
    assign op_kind   = kind_q;
    assign op_data   = data_q;
    assign peek_addr = tgt_q;
    assign start     = !busy && (launch.kind != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= OP_NONE;
            cnt_q  <= '0;
            last_q <= '0;
            span_q <= '0;
            base_q <= '0;
            tgt_q  <= '0;
            data_q <= '0;
        end else if (start) begin
            kind_q <= launch.kind;
            cnt_q  <= '0;
            tgt_q  <= launch.addr[ARRAY_AW-1:0];
            data_q <= launch.data;
            unique case (launch.kind)
                OP_PROG: begin
                    span_q <= '0;
                    last_q <= CW'(PROG_CYC - 1);
                end
                OP_SECT: begin
                    base_q <= {launch.addr[ARRAY_AW-1:SECTOR_AW], {SECTOR_AW{1'b0}}};
                    span_q <= CW'(SECTOR_BYTES);
                    last_q <= CW'(SECTOR_BYTES + ERASE_TAIL - 1);
                end
                default: begin
                    base_q <= '0;
                    span_q <= CW'(ARRAY_BYTES);
                    last_q <= CW'(ARRAY_BYTES + ERASE_TAIL - 1);
                end
            endcase
        end else if (busy) begin
            if (cnt_q == last_q) kind_q <= OP_NONE;
            else                 cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        mem_we         = 1'b0;
        mem_clear_only = 1'b0;
        mem_addr       = tgt_q;
        mem_wdata      = 8'hFF;
        if (kind_q == OP_PROG) begin
            if (cnt_q == last_q) begin
                mem_we         = 1'b1;
                mem_clear_only = 1'b1;
                mem_wdata      = peek_q & data_q;
            end
        end else if (busy && (cnt_q < span_q)) begin
            mem_we   = 1'b1;
            mem_addr = base_q + cnt_q[ARRAY_AW-1:0];
        end
    end

    p_launch_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (launch.kind != OP_NONE) |=> busy);

    p_no_launch_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (launch.kind == OP_NONE));

    generate
        if (SEL_W > 0) begin : g_sect_chk
            p_sector_bound_r4: assert property (@(posedge clk) disable iff (rst)
                (kind_q == OP_SECT && mem_we) |->
                (mem_addr[ARRAY_AW-1:SECTOR_AW] == tgt_q[ARRAY_AW-1:SECTOR_AW]));
        end
    endgenerate

endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          clear_only,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] peek_addr,
    output logic [7:0]    peek_q,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rq
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    assign peek_q = mem[peek_addr];
    assign rq     = mem[raddr];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Program writes may only clear bits of the stored byte (R3)
    p_prog_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (we && clear_only) |-> ((wdata & ~mem[waddr]) == 8'h00));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ARRAY_AW   = 13,
    parameter int SECTOR_AW  = 12,
    parameter int PROG_CYC   = 50,
    parameter int ERASE_TAIL = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        busy
);

    launch_t             launch;
    op_e                 op_kind;
    logic [7:0]          op_data;
    logic [ARRAY_AW-1:0] peek_addr, mem_addr;
    logic [7:0]          peek_q, mem_wdata, arr_q;
    logic                mem_we, mem_clear_only;
    logic                tog_q;

    flash_seq_decoder u_dec (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .busy   (busy),
        .launch (launch)
    );

    flash_op_engine #(
        .ARRAY_AW   (ARRAY_AW),
        .SECTOR_AW  (SECTOR_AW),
        .PROG_CYC   (PROG_CYC),
        .ERASE_TAIL (ERASE_TAIL)
    ) u_eng (
        .clk            (clk),
        .rst            (rst),
        .launch         (launch),
        .busy           (busy),
        .op_kind        (op_kind),
        .op_data        (op_data),
        .peek_addr      (peek_addr),
        .peek_q         (peek_q),
        .mem_we         (mem_we),
        .mem_clear_only (mem_clear_only),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata)
    );

    flash_array #(.AW(ARRAY_AW)) u_arr (
        .clk        (clk),
        .rst        (rst),
        .we         (mem_we),
        .clear_only (mem_clear_only),
        .waddr      (mem_addr),
        .wdata      (mem_wdata),
        .peek_addr  (peek_addr),
        .peek_q     (peek_q),
        .raddr      (addr[ARRAY_AW-1:0]),
        .rq         (arr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= 8'h00;
            tog_q <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata <= poll_status(op_kind, op_data, tog_q);
                tog_q <= ~tog_q;
            end else begin
                rdata <= arr_q;
            end
        end
    end

    p_status_low_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rdata[5:0] == 6'd0));

    p_hold_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

    localparam int AW    = 13;
    localparam int SW    = 12;
    localparam int PCYC  = 50;
    localparam int TAIL  = 16;
    localparam int NBYTE = 1 << AW;
    localparam int SBYTE = 1 << SW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] model [NBYTE];

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ARRAY_AW(AW), .SECTOR_AW(SW), .PROG_CYC(PCYC), .ERASE_TAIL(TAIL)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    function automatic logic [7:0] exp_prog(input logic [7:0] old, input logic [7:0] d);
        return old & d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a);
        logic [7:0] v;
        bus_rd(a, v);
        chk(req, v, model[a[AW-1:0]]);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_prog(input logic [15:0] a, input logic [7:0] d);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(a, d);
        model[a[AW-1:0]] = exp_prog(model[a[AW-1:0]], d);
    endtask

    task automatic erase_prefix();
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'h80);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
    endtask

    task automatic do_sect(input logic [15:0] a);
        erase_prefix();
        bus_wr(a, 8'h30);
        for (int k = 0; k < SBYTE; k++) model[{a[AW-1:SW], SW'(k)}] = 8'hFF;
    endtask

    task automatic do_chip();
        erase_prefix();
        bus_wr(16'h5555, 8'h10);
        for (int k = 0; k < NBYTE; k++) model[k] = 8'hFF;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int n;
        logic [7:0] v, v2;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NBYTE; k++) model[k] = 8'h00;

        repeat (3) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 rdata after reset", rdata, 8'h00);
        rst = 1'b0;

        // whole-array erase
        do_chip();
        chk("R5 busy after chip erase launch", busy, 1);
        bus_rd(16'h0040, v);
        chk("R9 erase status bit7", v[7], 0);
        chk("R9 erase status low bits", v[5:0], 0);
        wait_idle(n);
        chk("R6 chip erase busy length", n + 2, NBYTE + TAIL);
        rd_chk("R5 chip erase first byte", 16'h0000);
        rd_chk("R5 chip erase last byte", 16'h1FFF);
        rd_chk("R5 chip erase mid byte", 16'h0ABC);

        // program with status polling
        do_prog(16'h0123, 8'h5A);
        bus_rd(16'h0123, v);
        bus_rd(16'h0123, v2);
        chk("R9 program status bit7", v[7], 1);
        chk("R9 program status low bits", v[5:0], 0);
        chk("R9 toggle bit alternates", v[6] ^ v2[6], 1);
        wait_idle(n);
        chk("R2 program busy length", n + 4, PCYC);
        rd_chk("R2 programmed byte", 16'h0123);

        // bit-clearing only
        do_prog(16'h0123, 8'hA5);
        wait_idle(n);
        chk("R2 program busy length again", n, PCYC);
        rd_chk("R3 and of opposing data", 16'h0123);
        do_prog(16'h0123, 8'hFF);
        wait_idle(n);
        bus_rd(16'h0123, v);
        chk("R3 cannot raise bits", v, 8'h00);

        // writes while busy
        do_prog(16'h0200, 8'h0F);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(16'h0300, 8'h00);
        wait_idle(n);
        rd_chk("R8 target of ignored program", 16'h0300);
        rd_chk("R8 running program result", 16'h0200);
        bus_wr(16'h0300, 8'h00);
        chk("R8 no stale sequence after busy", busy, 0);

        // broken sequences
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5554, 8'hA0);
        bus_wr(16'h0400, 8'h00);
        chk("R7 wrong command address no launch", busy, 0);
        rd_chk("R7 byte unchanged after break", 16'h0400);
        erase_prefix();
        bus_wr(16'h5554, 8'h10);
        chk("R7 whole erase wrong address", busy, 0);
        erase_prefix();
        bus_wr(16'h1000, 8'h20);
        chk("R7 wrong final erase byte", busy, 0);
        rd_chk("R7 array intact after breaks", 16'h0123);

        // sector erase beside a programmed neighbour
        do_prog(16'h1010, 8'h33);
        wait_idle(n);
        do_prog(16'h0FFF, 8'h44);
        wait_idle(n);
        do_sect(16'h1234);
        wait_idle(n);
        chk("R6 sector erase busy length", n, SBYTE + TAIL);
        rd_chk("R4 erased byte in sector", 16'h1010);
        rd_chk("R4 sector first byte", 16'h1000);
        rd_chk("R4 sector last byte", 16'h1FFF);
        rd_chk("R4 neighbour sector kept", 16'h0FFF);
        rd_chk("R4 neighbour sector kept 2", 16'h0200);

        // read latency and hold
        bus_rd(16'h0200, v);
        chk("R10 idle read returns array", v, model[13'h0200]);
        addr = 16'h0FFF;
        repeat (3) @(negedge clk);
        chk("R10 rdata holds without rd_en", rdata, model[13'h0200]);

        // constrained random phase
        for (int i = 0; i < 50; i++) begin
            int sel;
            logic [15:0] a;
            logic [7:0]  d;
            sel = $urandom_range(0, 9);
            a   = 16'($urandom);
            d   = 8'($urandom);
            if (sel < 7) begin
                do_prog(a, d);
                wait_idle(n);
                chk("R2 random program length", n, PCYC);
                rd_chk("R3 random program byte", a);
            end else if (sel < 8) begin
                bus_wr(16'h5555, 8'hAA);
                bus_wr(16'h2AAA, 8'h56);
                bus_wr(a, 8'h00);
                chk("R7 random break no launch", busy, 0);
                rd_chk("R7 random break byte", a);
            end else begin
                do_sect(a);
                wait_idle(n);
                chk("R6 random sector length", n, SBYTE + TAIL);
                for (int j = 0; j < 4; j++) begin
                    logic [15:0] b;
                    b = 16'($urandom);
                    rd_chk("R4 random sector sample", b);
                end
            end
        end

        summary();
        $finish;
    end

endmodule